// File: doc/BRIEF.md
# Display Test Pattern Generator

This block sits in a video output path and can stand in for the incoming pixel stream with a synthetic image. Each cycle the upstream timing logic presents a pixel position, a valid strobe and three 16-bit colour components. When the generator is armed, pixels inside a programmable rectangle that starts at the origin are replaced by one of five patterns. These are an eight-colour checkerboard of squares, vertical stripes, horizontal stripes, a single horizontal gradient, and a two-band gradient. Every other pixel passes through untouched. A solid fill for blanking is obtained by selecting horizontal stripes with both stripe colours equal.

Software programs the generator through a small word-wide register port. All pattern settings are double-buffered. A write lands in a shadow copy, and the whole shadow set moves into the working copy on the next frame-start strobe, so a frame never shows a mix of old and new settings. An update-pending flag and a blanked indication tell software when its settings have taken effect. Colour components are 16-bit and left-justified. The output keeps only as many top bits as the selected bit depth asks for.

Top module: `testpat_gen`

## Requirements
- R1: While and directly after reset, the outputs `out_valid`, `out_r/g/b`, `cfg_rdata`, `upd_pending` and `blanked` are zero, and the working settings are all zero, so video is passed through.
- R2: The output is registered with one cycle of latency. It equals the input pixel of the previous cycle when any of these holds: the working enable bit is 0; the working mode code is above 4; the pixel is outside the region (x >= width or y >= height). Writing zero to the control, colour and ramp registers and then strobing frame start gives this passthrough.
- R3: Register map, read with one cycle of latency from the shadow copy. Address 0 is control: bit 0 enable, bits 3:1 mode, bit 4 range (0 full scale, 1 limited), bits 6:5 depth code, bits 10:8 vertical shift V, bits 14:12 horizontal shift H. Address 1 holds width in bits 15:0 and height in bits 31:16. Addresses 2, 3 and 4 are red, green and blue, each with colour0 in bits 15:0 and colour1 in bits 31:16. Address 5 holds the ramp offset in bits 15:0, step exponent A in bits 19:16 and step exponent B in bits 23:20. Address 6 is read-only status: bit 0 pending, bit 1 blanked. Bits 3:0 of every colour value read as zero and act as zero. Unlisted bits read zero.
- R4: A write to addresses 0 to 5 changes only the shadow copy and sets `upd_pending`. A frame-start strobe copies the shadow into the working copy and clears pending. A write in the same cycle as frame start is not part of that copy, and pending stays set. Writes to addresses 6 and 7 change nothing.
- R5: `blanked` is 1 exactly when the working enable bit is 1 and no update is pending.
- R6: Mode 1 (vertical stripes) outputs colour1 where bit 0 of (x >> H) is 1 and colour0 otherwise.
- R7: Mode 2 (horizontal stripes) outputs colour1 where bit 0 of (y >> V) is 1 and colour0 otherwise. With colour0 equal to colour1 the region is a solid fill.
- R8: Mode 0 (squares) computes k = ((x >> H) + (y >> V)) mod 8. Red, green and blue take their high level when bits 2, 1 and 0 of k are set, and their low level otherwise. The levels are 0xFFFF/0x0000 at full scale and 0xEB00/0x1000 at limited range.
- R9: Mode 3 (single ramp) outputs offset + (x << A) on all three components, clamped to 0xFFFF.
- R10: Mode 4 (dual ramp) outputs x << A on lines where bit 0 of (y >> V) is 0, and offset + (x << B) on the other lines. Both are clamped to 0xFFFF and applied to all components.
- R11: Every generated component is masked to its top N bits, where N is 6, 8, 10 or 12 for depth codes 0, 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for the address of the previous cycle |
| frame_start | input | 1 | Frame-start strobe that applies the shadow settings |
| vid_valid | input | 1 | Input pixel valid |
| pix_x | input | PIX_W | Horizontal position of the input pixel |
| pix_y | input | PIX_W | Vertical position of the input pixel |
| vid_r | input | 16 | Input red component |
| vid_g | input | 16 | Input green component |
| vid_b | input | 16 | Input blue component |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 16 | Output red component |
| out_g | output | 16 | Output green component |
| out_b | output | 16 | Output blue component |
| upd_pending | output | 1 | Shadow settings are waiting for frame start |
| blanked | output | 1 | Generator is armed with no pending update |

## Verification
The case of interest is a register write that lands in the same cycle as the frame-start strobe. The bench raises the write strobe and frame start together, with a new control word, while an older pattern is working. It then requires three things: pending still reads 1; the next pixels still follow the older pattern; the new pattern appears only after a later frame start. Each mode is swept over a small region plus a margin outside it, and every output pixel is compared with values worked out from the requirement formulas.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int CW     = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int NCOMP  = 3;

  localparam logic [2:0] MODE_SQUARES = 3'd0;
  localparam logic [2:0] MODE_VBARS   = 3'd1;
  localparam logic [2:0] MODE_HBARS   = 3'd2;
  localparam logic [2:0] MODE_RAMP    = 3'd3;
  localparam logic [2:0] MODE_DUAL    = 3'd4;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIMS   = 3'd1;
  localparam logic [ADDR_W-1:0] A_COL_R  = 3'd2;
  localparam logic [ADDR_W-1:0] A_COL_G  = 3'd3;
  localparam logic [ADDR_W-1:0] A_COL_B  = 3'd4;
  localparam logic [ADDR_W-1:0] A_RAMP   = 3'd5;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd6;

  localparam logic [CW-1:0] FULL_HI = 16'hFFFF;
  localparam logic [CW-1:0] FULL_LO = 16'h0000;
  localparam logic [CW-1:0] LIM_HI  = 16'hEB00;
  localparam logic [CW-1:0] LIM_LO  = 16'h1000;
  localparam logic [CW-1:0] NIB_CUT = 16'hFFF0;

  typedef logic [NCOMP-1:0][CW-1:0] pix3_t;

  typedef struct packed {
    logic          en;
    logic [2:0]    mode;
    logic          lim;
    logic [1:0]    depth;
    logic [2:0]    vsh;
    logic [2:0]    hsh;
    logic [CW-1:0] width;
    logic [CW-1:0] height;
    pix3_t         col0;
    pix3_t         col1;
    logic [CW-1:0] ofs;
    logic [3:0]    stepa;
    logic [3:0]    stepb;
  } cfg_t;

  function automatic logic [CW-1:0] depth_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 16'hFC00;
      2'd1:    return 16'hFF00;
      2'd2:    return 16'hFFC0;
      default: return 16'hFFF0;
    endcase
  endfunction
endpackage

// File: rtl/tpg_regs.sv
module tpg_regs
  import tpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              frame_start,
  output logic [DATA_W-1:0] rdata,
  output cfg_t              act,
  output logic              pending,
  output logic              blanked
);
  cfg_t sh;
  logic cfg_wr;

  assign cfg_wr  = we && (addr <= A_RAMP);
  assign blanked = act.en && !pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      act     <= '0;
      pending <= 1'b0;
      rdata   <= '0;
    end else begin
      if (we) begin
        case (addr)
          A_CTRL: begin
            sh.en    <= wdata[0];
            sh.mode  <= wdata[3:1];
            sh.lim   <= wdata[4];
            sh.depth <= wdata[6:5];
            sh.vsh   <= wdata[10:8];
            sh.hsh   <= wdata[14:12];
          end
          A_DIMS: begin
            sh.width  <= wdata[15:0];
            sh.height <= wdata[31:16];
          end
          A_COL_R, A_COL_G, A_COL_B: begin
            sh.col0[addr-A_COL_R] <= wdata[15:0] & NIB_CUT;
            sh.col1[addr-A_COL_R] <= wdata[31:16] & NIB_CUT;
          end
          A_RAMP: begin
            sh.ofs   <= wdata[15:0];
            sh.stepa <= wdata[19:16];
            sh.stepb <= wdata[23:20];
          end
          default: ;
        endcase
      end
      if (frame_start) act <= sh;
      if (cfg_wr) pending <= 1'b1;
      else if (frame_start) pending <= 1'b0;
      case (addr)
        A_CTRL:   rdata <= {17'b0, sh.hsh, 1'b0, sh.vsh, 1'b0, sh.depth, sh.lim, sh.mode, sh.en};
        A_DIMS:   rdata <= {sh.height, sh.width};
        A_COL_R:  rdata <= {sh.col1[0], sh.col0[0]};
        A_COL_G:  rdata <= {sh.col1[1], sh.col0[1]};
        A_COL_B:  rdata <= {sh.col1[2], sh.col0[2]};
        A_RAMP:   rdata <= {8'b0, sh.stepb, sh.stepa, sh.ofs};
        A_STATUS: rdata <= {30'b0, blanked, pending};
        default:  rdata <= '0;
      endcase
    end
  end

  // R4: a settings write always leaves an update pending
  a_r4_pend_set: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> pending);
  // R4: a frame start without a coincident write retires the update
  a_r4_pend_clear: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !cfg_wr) |=> !pending);
  // R4: working settings move only on frame start
  a_r4_act_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(act));
  // R4: frame start loads exactly the prior shadow
  a_r4_act_load: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (act == $past(sh)));
endmodule

// File: rtl/tpg_pattern.sv
module tpg_pattern
  import tpg_pkg::*;
#(
  parameter int PIX_W = 12
) (
  input  cfg_t             cfg,
  input  logic [PIX_W-1:0] x,
  input  logic [PIX_W-1:0] y,
  output logic             hit,
  output pix3_t            pix
);
  logic [CW-1:0] xcell, ycell, mask, hi_lvl, lo_lvl, ramp_v;
  logic [2:0]    sq;
  logic [31:0]   r_single, r_band0, r_band1, r_sel;

  assign xcell  = CW'(x) >> cfg.hsh;
  assign ycell  = CW'(y) >> cfg.vsh;
  assign sq     = xcell[2:0] + ycell[2:0];
  assign mask   = depth_mask(cfg.depth);
  assign hi_lvl = cfg.lim ? LIM_HI : FULL_HI;
  assign lo_lvl = cfg.lim ? LIM_LO : FULL_LO;

  assign r_single = {16'b0, cfg.ofs} + (32'(x) << cfg.stepa);
  assign r_band0  = 32'(x) << cfg.stepa;
  assign r_band1  = {16'b0, cfg.ofs} + (32'(x) << cfg.stepb);
  assign r_sel    = (cfg.mode == MODE_DUAL) ? (ycell[0] ? r_band1 : r_band0) : r_single;
  assign ramp_v   = (|r_sel[31:16]) ? 16'hFFFF : r_sel[15:0];

  assign hit = cfg.en && (CW'(x) < cfg.width) && (CW'(y) < cfg.height)
               && (cfg.mode <= MODE_DUAL);

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    logic [CW-1:0] raw;
    always_comb begin
      case (cfg.mode)
        MODE_SQUARES: raw = sq[2-c] ? hi_lvl : lo_lvl;
        MODE_VBARS:   raw = xcell[0] ? cfg.col1[c] : cfg.col0[c];
        MODE_HBARS:   raw = ycell[0] ? cfg.col1[c] : cfg.col0[c];
        default:      raw = ramp_v;
      endcase
    end
    assign pix[c] = raw & mask;
  end
endmodule

// File: rtl/testpat_gen.sv
module testpat_gen
  import tpg_pkg::*;
#(
  parameter int PIX_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              frame_start,
  input  logic              vid_valid,
  input  logic [PIX_W-1:0]  pix_x,
  input  logic [PIX_W-1:0]  pix_y,
  input  logic [15:0]       vid_r,
  input  logic [15:0]       vid_g,
  input  logic [15:0]       vid_b,
  output logic              out_valid,
  output logic [15:0]       out_r,
  output logic [15:0]       out_g,
  output logic [15:0]       out_b,
  output logic              upd_pending,
  output logic              blanked
);
  cfg_t  act;
  logic  hit;
  pix3_t gen;

  tpg_regs u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .frame_start(frame_start), .rdata(cfg_rdata), .act(act),
    .pending(upd_pending), .blanked(blanked)
  );

  tpg_pattern #(.PIX_W(PIX_W)) u_pat (
    .cfg(act), .x(pix_x), .y(pix_y), .hit(hit), .pix(gen)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_r     <= '0;
      out_g     <= '0;
      out_b     <= '0;
    end else begin
      out_valid <= vid_valid;
      out_r     <= hit ? gen[0] : vid_r;
      out_g     <= hit ? gen[1] : vid_g;
      out_b     <= hit ? gen[2] : vid_b;
    end
  end

  // R2: a disarmed generator forwards the previous input pixel
  a_r2_passthru: assert property (@(posedge clk) disable iff (rst)
    !act.en |=> (out_r == $past(vid_r) && out_g == $past(vid_g) && out_b == $past(vid_b)));
  // R2: output valid tracks input valid with one cycle of delay
  a_r2_valid_lat: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(vid_valid)));
  // R5: blanking can only begin at a frame start
  a_r5_blank_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(blanked) |-> $past(frame_start));
endmodule

// File: tb/testpat_gen_test.sv
`timescale 1ns/1ps
module testpat_gen_test;
  localparam int PW = 12;
  localparam int W  = 20;
  localparam int H  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic frame_start = 1'b0;
  logic vid_valid = 1'b0;
  logic [PW-1:0] pix_x = '0, pix_y = '0;
  logic [15:0] vid_r = '0, vid_g = '0, vid_b = '0;
  logic out_valid, upd_pending, blanked;
  logic [15:0] out_r, out_g, out_b;

  int checks = 0;
  int errors = 0;
  logic [31:0] sh_reg [0:5];
  logic [31:0] ac_reg [0:5];

  always #4 clk = ~clk;

  testpat_gen #(.PIX_W(PW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .frame_start(frame_start), .vid_valid(vid_valid),
    .pix_x(pix_x), .pix_y(pix_y), .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .upd_pending(upd_pending), .blanked(blanked)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] keep_bits(input int a, input logic [31:0] d);
    case (a)
      0: return d & 32'h0000_777F;
      2, 3, 4: return d & 32'hFFF0_FFF0;
      5: return d & 32'h00FF_FFFF;
      default: return d;
    endcase
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a[2:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a <= 5) sh_reg[a] = keep_bits(a, d);
  endtask

  task automatic fs();
    frame_start = 1'b1; vid_valid = 1'b0;
    @(negedge clk);
    frame_start = 1'b0;
    for (int i = 0; i < 6; i++) ac_reg[i] = sh_reg[i];
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    cfg_addr = a[2:0];
    @(negedge clk);
    d = cfg_rdata;
  endtask

  function automatic logic [15:0] vin(input int c, input int x, input int y);
    return 16'((x * 2731 + y * 977 + c * 8191 + 5) & 16'hFFFF);
  endfunction

  function automatic logic [15:0] model(input int c, input int x, input int y);
    logic [31:0] ct = ac_reg[0];
    int mode = int'(ct[3:1]);
    int depth = int'(ct[6:5]);
    int vs = int'(ct[10:8]);
    int hs = int'(ct[14:12]);
    int w = int'(ac_reg[1][15:0]);
    int h = int'(ac_reg[1][31:16]);
    logic [31:0] colw = ac_reg[2 + c];
    int ofs = int'(ac_reg[5][15:0]);
    int sa = int'(ac_reg[5][19:16]);
    int sb = int'(ac_reg[5][23:20]);
    int v, k, s;
    int bits = 6 + 2 * depth;
    if (!ct[0] || x >= w || y >= h || mode > 4) return vin(c, x, y);
    case (mode)
      0: begin
        k = ((x >> hs) + (y >> vs)) % 8;
        if (((k >> (2 - c)) & 1) == 1) v = ct[4] ? 32'hEB00 : 32'hFFFF;
        else v = ct[4] ? 32'h1000 : 0;
      end
      1: v = (((x >> hs) & 1) == 1) ? int'(colw[31:16]) : int'(colw[15:0]);
      2: v = (((y >> vs) & 1) == 1) ? int'(colw[31:16]) : int'(colw[15:0]);
      3: begin s = ofs + (x << sa); v = (s > 65535) ? 65535 : s; end
      default: begin
        if (((y >> vs) & 1) == 1) s = ofs + (x << sb); else s = x << sa;
        v = (s > 65535) ? 65535 : s;
      end
    endcase
    return 16'(v & ((32'hFFFF << (16 - bits)) & 32'hFFFF));
  endfunction

  task automatic pix(input string req, input int x, input int y);
    logic [47:0] e;
    vid_valid = 1'b1; pix_x = PW'(x); pix_y = PW'(y);
    vid_r = vin(0, x, y); vid_g = vin(1, x, y); vid_b = vin(2, x, y);
    e = {model(0, x, y), model(1, x, y), model(2, x, y)};
    @(negedge clk);
    check(req, {15'b0, out_valid, out_r, out_g, out_b}, {15'b0, 1'b1, e});
    vid_valid = 1'b0;
  endtask

  task automatic sweep(input string req);
    for (int y = 0; y < H + 2; y++)
      for (int x = 0; x < W + 3; x++)
        pix(req, x, y);
  endtask

  function automatic logic [31:0] ctrl(input int en, input int mode, input int lim,
                                       input int depth, input int vs, input int hs);
    return 32'(en | (mode << 1) | (lim << 4) | (depth << 5) | (vs << 8) | (hs << 12));
  endfunction

  initial begin
    #(8ns * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 6; i++) begin sh_reg[i] = '0; ac_reg[i] = '0; end
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", {out_valid, out_r, out_g, out_b, upd_pending, blanked, cfg_rdata}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {upd_pending, blanked}, '0);
    // R2: passthrough out of reset
    pix("R2", 3, 2);
    pix("R2", 100, 50);

    // R3: colour low nibble masking and shadow readback
    wr(2, 32'hFFFF_1234);
    rd(2, d); check("R3", d, 32'hFFF0_1230);
    check("R4", upd_pending, 1'b1);
    pix("R4", 1, 1);            // shadow only, still passthrough
    wr(3, 32'hABCD_0F0F); wr(4, 32'h8001_7FFF);
    wr(1, {16'(H), 16'(W)});
    wr(0, ctrl(1, 1, 0, 1, 0, 2));
    wr(2, 32'hFEDC_1234);
    rd(0, d); check("R3", d, 32'h0000_2023);
    rd(1, d); check("R3", d, {16'(H), 16'(W)});
    check("R5", blanked, 1'b0);
    fs();
    check("R4", upd_pending, 1'b0);
    check("R5", blanked, 1'b1);
    rd(6, d); check("R3", d, 32'h2);
    sweep("R6");

    // R4: writes to status / unused address change nothing
    wr(6, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF);
    check("R4", upd_pending, 1'b0);
    pix("R4", 5, 1);

    // R7: horizontal bars at 6 bpc, then solid fill at 12 bpc
    wr(0, ctrl(1, 2, 0, 0, 1, 0));
    check("R5", blanked, 1'b0);
    fs(); sweep("R7");
    wr(2, 32'h5A5F_5A5F); wr(3, 32'h1237_1237); wr(4, 32'hC3C3_C3C3);
    wr(0, ctrl(1, 2, 0, 3, 0, 0));
    fs(); sweep("R7");

    // R8: squares full scale and limited range
    wr(0, ctrl(1, 0, 0, 2, 1, 1)); fs(); sweep("R8");
    wr(0, ctrl(1, 0, 1, 1, 0, 2)); fs(); sweep("R8");

    // R9: single ramp saturating; R11 at 8 bpc
    wr(5, 32'h000B_8000);
    wr(0, ctrl(1, 3, 0, 1, 0, 0)); fs(); sweep("R9");
    rd(5, d); check("R3", d, 32'h000B_8000);

    // R10: dual ramp, offset 384<<6
    wr(5, 32'h00A8_6000);
    wr(0, ctrl(1, 4, 0, 2, 1, 0)); fs(); sweep("R10");
    wr(5, 32'h00FC_4000);
    wr(0, ctrl(1, 4, 0, 3, 0, 0)); fs(); sweep("R11");

    // R4: write coincident with frame start is deferred
    wr(0, ctrl(1, 1, 0, 1, 0, 2)); fs();
    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = ctrl(1, 2, 0, 0, 1, 0);
    frame_start = 1'b1; vid_valid = 1'b0;
    for (int i = 0; i < 6; i++) ac_reg[i] = sh_reg[i];
    sh_reg[0] = keep_bits(0, cfg_wdata);
    @(negedge clk);
    cfg_we = 1'b0; frame_start = 1'b0;
    check("R4", upd_pending, 1'b1);
    check("R5", blanked, 1'b0);
    for (int x = 0; x < 12; x++) pix("R4", x, 1);
    fs();
    check("R4", upd_pending, 1'b0);
    for (int x = 0; x < 12; x++) pix("R4", x, 2);

    // R2: unsupported mode, then zeroed registers
    wr(0, ctrl(1, 6, 0, 1, 0, 0)); fs(); sweep("R2");
    wr(0, 0); wr(2, 0); wr(3, 0); wr(4, 0); wr(5, 0); fs();
    check("R5", blanked, 1'b0);
    sweep("R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule